// File: doc/BRIEF.md
# Rendezvous Message-Passing Network Interface

This block sits between a processor core and the local port of a mesh router and moves messages only when the receiving node asks for them. When the core sends, the interface collects the outgoing words into a small local buffer. It also prepares a head flit addressed to the destination. Nothing leaves the node at that point. The packet is released only when a data-request flit arrives from exactly that destination.

When the core wants to receive, the interface emits a single request flit toward the chosen source node and arms a timer. If the data packet from that source has not started to arrive when the timer runs out, the request is emitted again, and the timer restarts from the new request. Incoming payload words of the expected packet are passed straight to the core. Every flit handed to the router is held and re-offered until the router acknowledges it. At most one send and one receive are outstanding at any time.

Top module: `msg_nic`

## Requirements
- R1: After reset, out_valid, rx_valid, snd_busy and rcv_busy are all low.
- R2: Send words are accepted on snd_valid while snd_busy is low. The first word sets the destination. Loading ends on snd_last or on the DEPTH-th word, whichever comes first. snd_busy then rises and no data flit is presented until a matching request arrives.
- R3: Flit layout, with bit 31 as MSB. Bits [31:30] carry the type: 01 = data-request, 10 = packet head. Bits [29:26] and [25:22] carry the destination x and y. Bits [21:18] and [17:14] carry the sender x and y. Bits [13:0] carry the payload word count in a head and are zero in a request. Payload flits are raw 32-bit words.
- R4: A rcv_cmd while rcv_busy is low raises rcv_busy and presents exactly one request flit, whose destination is (rcv_src_x, rcv_src_y) and whose sender is (node_x, node_y).
- R5: In the waiting state, an incoming request whose sender equals the buffered destination starts the packet: a head, then every buffered word in load order. snd_busy falls after the last word is acknowledged. A request from any other node is ignored.
- R6: A flit presented without out_ack is presented again, unchanged, in the next cycle, and no other flit takes its place.
- R7: If no matching head has arrived TIMEOUT cycles after a request is acknowledged, the request is presented again. The count restarts from each acknowledged request.
- R8: A head from the expected source while waiting cancels the timer. Its payload words appear on rx_data with rx_valid in the same cycle as they arrive on in_flit, and rx_last marks the final one. rcv_busy then falls. Packets from other sources are consumed without any rx_valid.
- R9: snd_valid while snd_busy is high, and rcv_cmd while rcv_busy is high, have no effect.
- R10: When a request and an unstarted packet both wait for the link, the request goes first. Once a packet's head has been accepted, no request is inserted before its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | 4 | This node's x coordinate |
| node_y | input | 4 | This node's y coordinate |
| snd_valid | input | 1 | Send word strobe |
| snd_data | input | 32 | Send word |
| snd_last | input | 1 | Final word of the message |
| snd_dst_x | input | 4 | Destination x, sampled with the first word |
| snd_dst_y | input | 4 | Destination y, sampled with the first word |
| snd_busy | output | 1 | A loaded message is waiting or being sent |
| rcv_cmd | input | 1 | Receive command strobe |
| rcv_src_x | input | 4 | Source node x for the receive |
| rcv_src_y | input | 4 | Source node y for the receive |
| rcv_busy | output | 1 | A receive is outstanding |
| rx_valid | output | 1 | Received payload word valid |
| rx_data | output | 32 | Received payload word |
| rx_last | output | 1 | Final received word |
| out_valid | output | 1 | Flit offered to the router |
| out_flit | output | 32 | Offered flit |
| out_ack | input | 1 | Router accepts the offered flit; low means refused |
| in_valid | input | 1 | Flit from the router |
| in_flit | input | 32 | Incoming flit |

## Verification
Two functions can need the same cycle. The first pair is a pending request and an unstarted packet, both asking for the single outgoing link. The second pair is the expiry of the retry timer and the arrival of the awaited head. The bench provokes the first by delivering the matching request in the same cycle as a receive command, refusing the first offered flit, and letting a retry fall due in the middle of a packet. It provokes the second by placing the head exactly TIMEOUT cycles after the request is acknowledged. A queue-based model predicts every output in every cycle, and the bench judges the design against it, including which flit wins and whether a spurious retry appears.

// File: rtl/msg_nic.sv
module msg_nic #(
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  node_x,
  input  logic [3:0]  node_y,
  input  logic        snd_valid,
  input  logic [31:0] snd_data,
  input  logic        snd_last,
  input  logic [3:0]  snd_dst_x,
  input  logic [3:0]  snd_dst_y,
  output logic        snd_busy,
  input  logic        rcv_cmd,
  input  logic [3:0]  rcv_src_x,
  input  logic [3:0]  rcv_src_y,
  output logic        rcv_busy,
  output logic        rx_valid,
  output logic [31:0] rx_data,
  output logic        rx_last,
  output logic        out_valid,
  output logic [31:0] out_flit,
  input  logic        out_ack,
  input  logic        in_valid,
  input  logic [31:0] in_flit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [1:0] T_REQ  = 2'b01;
  localparam logic [1:0] T_HEAD = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_XMIT} snd_t;
  typedef enum logic [1:0] {R_IDLE, R_WAIT, R_DATA} rcv_t;

  snd_t sst;
  rcv_t rstate;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wcnt, last, pidx;
  logic          hdr_sent;
  logic [7:0]    dst, exp_src;
  logic          req_pend, run, lock, lock_req, in_match;
  logic [TW-1:0] tmr;
  logic [13:0]   in_cnt;

  wire [7:0] in_src   = in_flit[21:14];
  wire       in_ctl   = in_valid && (in_cnt == 14'd0);
  wire       req_hit  = in_ctl && in_flit[31:30] == T_REQ && sst == S_WAIT && in_src == dst;
  wire       head_hit = in_ctl && in_flit[31:30] == T_HEAD && rstate == R_WAIT && in_src == exp_src;

  wire sel_req  = lock ? lock_req : (req_pend && !(sst == S_XMIT && hdr_sent));
  wire req_acc  = sel_req && out_ack;
  wire data_acc = out_valid && !sel_req && out_ack;

  wire [31:0] req_flit  = {T_REQ, exp_src, node_x, node_y, 14'd0};
  wire [31:0] head_flit = {T_HEAD, dst, node_x, node_y, 14'(last) + 14'd1};

  assign out_valid = sel_req || sst == S_XMIT;
  assign out_flit  = sel_req ? req_flit : (hdr_sent ? mem[pidx] : head_flit);
  assign snd_busy  = sst == S_WAIT || sst == S_XMIT;
  assign rcv_busy  = rstate != R_IDLE;
  assign rx_valid  = in_valid && in_cnt != 14'd0 && in_match;
  assign rx_data   = in_flit;
  assign rx_last   = rx_valid && in_cnt == 14'd1;

  wire           wr_en  = snd_valid && (sst == S_IDLE || sst == S_LOAD);
  wire [AW-1:0]  wr_idx = (sst == S_IDLE) ? '0 : wcnt;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_idx] <= snd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sst <= S_IDLE; wcnt <= '0; last <= '0; pidx <= '0; hdr_sent <= 1'b0; dst <= '0;
    end else begin
      case (sst)
        S_IDLE: if (snd_valid) begin
          dst  <= {snd_dst_x, snd_dst_y};
          wcnt <= AW'(1);
          last <= '0;
          sst  <= (snd_last || DEPTH == 1) ? S_WAIT : S_LOAD;
        end
        S_LOAD: if (snd_valid) begin
          wcnt <= wcnt + 1'b1;
          if (snd_last || wcnt == AW'(DEPTH - 1)) begin
            last <= wcnt;
            sst  <= S_WAIT;
          end
        end
        S_WAIT: if (req_hit) begin
          sst <= S_XMIT; hdr_sent <= 1'b0; pidx <= '0;
        end
        S_XMIT: if (data_acc) begin
          if (!hdr_sent)         hdr_sent <= 1'b1;
          else if (pidx == last) sst <= S_IDLE;
          else                   pidx <= pidx + 1'b1;
        end
        default: sst <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rstate <= R_IDLE; req_pend <= 1'b0; run <= 1'b0; tmr <= '0; exp_src <= '0;
    end else begin
      if (req_acc) begin
        req_pend <= 1'b0;
        if (rstate == R_WAIT) begin run <= 1'b1; tmr <= TW'(TIMEOUT); end
      end else if (run && !head_hit) begin
        if (tmr == TW'(1)) begin run <= 1'b0; req_pend <= 1'b1; end
        else tmr <= tmr - 1'b1;
      end
      if (rcv_cmd && rstate == R_IDLE) begin
        rstate <= R_WAIT; req_pend <= 1'b1; exp_src <= {rcv_src_x, rcv_src_y};
      end
      if (head_hit) begin run <= 1'b0; rstate <= R_DATA; end
      if (rx_last) rstate <= R_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt <= '0; in_match <= 1'b0; lock <= 1'b0; lock_req <= 1'b0;
    end else begin
      lock     <= out_valid && !out_ack;
      lock_req <= sel_req;
      if (in_valid) begin
        if (in_cnt != 14'd0) in_cnt <= in_cnt - 1'b1;
        else if (in_flit[31:30] == T_HEAD) begin
          in_cnt   <= in_flit[13:0];
          in_match <= head_hit;
        end
      end
    end
  end

  a_r6_nack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ack |=> out_valid && $stable(out_flit));
  a_r4_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_acc && rcv_busy |=> !sel_req);
  a_r8_rx_in_receive: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rcv_busy);
  a_r2_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snd_busy) |-> !(out_valid && !sel_req));
  a_r10_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !sel_req && !out_ack |=> out_valid && !sel_req);
endmodule

// File: tb/msg_nic_bench.sv
module msg_nic_bench;
  localparam int DEPTH = 4;
  localparam int TIMEOUT = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  node_x = 4'd1, node_y = 4'd1;
  logic        snd_valid = 0, snd_last = 0, rcv_cmd = 0, out_ack = 1, in_valid = 0;
  logic [31:0] snd_data = '0, in_flit = '0;
  logic [3:0]  snd_dst_x = '0, snd_dst_y = '0, rcv_src_x = '0, rcv_src_y = '0;
  logic        snd_busy, rcv_busy, rx_valid, rx_last, out_valid;
  logic [31:0] rx_data, out_flit;

  msg_nic #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) u_msg_nic (
    .clk, .rst_n, .node_x, .node_y, .snd_valid, .snd_data, .snd_last,
    .snd_dst_x, .snd_dst_y, .snd_busy, .rcv_cmd, .rcv_src_x, .rcv_src_y,
    .rcv_busy, .rx_valid, .rx_data, .rx_last, .out_valid, .out_flit,
    .out_ack, .in_valid, .in_flit);

  int total = 0, fails = 0;
  string tag = "R1";

  // behavioural model
  int ms, mrs, sidx, mtmr, mcnt;
  bit mrq, mrun, mmatch, mlock, mlreq;
  logic [3:0] mdx, mdy, msx, msy;
  logic [31:0] words[$];
  logic [31:0] pq[$];
  bit e_sel, e_ov, e_rxv, e_rxl;
  logic [31:0] e_flit;

  task automatic mreset();
    ms = 0; mrs = 0; sidx = 0; mtmr = 0; mcnt = 0;
    mrq = 0; mrun = 0; mmatch = 0; mlock = 0; mlreq = 0;
    mdx = 0; mdy = 0; msx = 0; msy = 0; words.delete(); pq.delete();
  endtask

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic calc();
    e_sel = mlock ? mlreq : (mrq && !(ms == 3 && sidx > 0));
    e_ov  = e_sel || ms == 3;
    e_flit = e_sel ? {2'b01, msx, msy, node_x, node_y, 14'd0} : (ms == 3 ? pq[sidx] : 32'd0);
    e_rxv = in_valid && mcnt > 0 && mmatch;
    e_rxl = e_rxv && mcnt == 1;
  endtask

  task automatic finish_load();
    pq.delete();
    pq.push_back({2'b10, mdx, mdy, node_x, node_y, 14'(words.size())});
    foreach (words[i]) pq.push_back(words[i]);
    ms = 2;
  endtask

  task automatic mupdate();
    bit req_acc, dat_acc, is_req, is_head, head_hit;
    req_acc = e_sel && out_ack;
    dat_acc = e_ov && !e_sel && out_ack;
    is_req  = in_valid && mcnt == 0 && in_flit[31:30] == 2'b01;
    is_head = in_valid && mcnt == 0 && in_flit[31:30] == 2'b10;
    head_hit = is_head && mrs == 1 && in_flit[21:14] == {msx, msy};
    case (ms)
      0: if (snd_valid) begin
           words.delete(); words.push_back(snd_data); mdx = snd_dst_x; mdy = snd_dst_y;
           if (snd_last || DEPTH == 1) finish_load(); else ms = 1;
         end
      1: if (snd_valid) begin
           words.push_back(snd_data);
           if (snd_last || words.size() == DEPTH) finish_load();
         end
      2: if (is_req && in_flit[21:14] == {mdx, mdy}) begin ms = 3; sidx = 0; end
      default: if (dat_acc) begin
           if (sidx == pq.size() - 1) ms = 0; else sidx++;
         end
    endcase
    if (req_acc) begin
      mrq = 0;
      if (mrs == 1) begin mrun = 1; mtmr = TIMEOUT; end
    end else if (mrun && !head_hit) begin
      if (mtmr == 1) begin mrun = 0; mrq = 1; end else mtmr--;
    end
    if (rcv_cmd && mrs == 0) begin mrs = 1; mrq = 1; msx = rcv_src_x; msy = rcv_src_y; end
    if (head_hit) begin mrun = 0; mrs = 2; end
    if (e_rxl) mrs = 0;
    if (in_valid) begin
      if (mcnt > 0) mcnt--;
      else if (is_head) begin mcnt = int'(in_flit[13:0]); mmatch = head_hit; end
    end
    mlock = e_ov && !out_ack;
    mlreq = e_sel;
  endtask

  task automatic cyc();
    #2;
    calc();
    if (rst_n) begin
      chk("out_valid", 32'(out_valid), 32'(e_ov));
      if (e_ov) chk("out_flit", out_flit, e_flit);
      chk("rx_valid", 32'(rx_valid), 32'(e_rxv));
      if (e_rxv) begin
        chk("rx_data", rx_data, in_flit);
        chk("rx_last", 32'(rx_last), 32'(e_rxl));
      end
      chk("snd_busy", 32'(snd_busy), 32'(ms >= 2));
      chk("rcv_busy", 32'(rcv_busy), 32'(mrs != 0));
    end
    @(posedge clk);
    if (!rst_n) mreset(); else mupdate();
    @(negedge clk);
    snd_valid = 0; snd_last = 0; rcv_cmd = 0; in_valid = 0; out_ack = 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic put_word(logic [31:0] d, bit lst, logic [3:0] x, logic [3:0] y);
    snd_valid = 1; snd_data = d; snd_last = lst; snd_dst_x = x; snd_dst_y = y;
    cyc();
  endtask

  task automatic put_req(logic [3:0] x, logic [3:0] y);
    in_valid = 1; in_flit = {2'b01, node_x, node_y, x, y, 14'd0};
    cyc();
  endtask

  task automatic put_head(logic [3:0] x, logic [3:0] y, int n);
    in_valid = 1; in_flit = {2'b10, node_x, node_y, x, y, 14'(n)};
    cyc();
  endtask

  task automatic put_pay(logic [31:0] d);
    in_valid = 1; in_flit = d;
    cyc();
  endtask

  task automatic ask(logic [3:0] x, logic [3:0] y);
    rcv_cmd = 1; rcv_src_x = x; rcv_src_y = y;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    mreset();
    @(negedge clk);
    idle(3);
    rst_n = 1;
    tag = "R1"; idle(2);
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);

    tag = "R2";
    put_word(32'hA0000001, 0, 4'd2, 4'd1);
    put_word(32'hA0000002, 0, 4'd9, 4'd9);
    put_word(32'hA0000003, 1, 4'd9, 4'd9);
    idle(4);
    tag = "R9"; put_word(32'hDEADBEEF, 1, 4'd3, 4'd3); idle(1);
    tag = "R5"; put_req(4'd3, 4'd3); idle(3);
    put_req(4'd2, 4'd1);
    tag = "R3/R6";
    for (int i = 0; i < 10; i++) begin out_ack = (i % 3 != 1); cyc(); end

    tag = "R4"; ask(4'd1, 4'd2); idle(2);
    tag = "R9"; ask(4'd3, 4'd3);
    tag = "R7"; idle(TIMEOUT + 4);
    tag = "R8";
    put_head(4'd1, 4'd2, 2); put_pay(32'h11110001); put_pay(32'h11110002); idle(2);

    ask(4'd2, 4'd2); idle(1);
    put_head(4'd3, 4'd0, 2); put_pay(32'h55550001); put_pay(32'h55550002);
    put_head(4'd2, 4'd2, 1); put_pay(32'h22220001); idle(2);

    tag = "R10";
    put_word(32'hB0000001, 0, 4'd0, 4'd1);
    put_word(32'hB0000002, 1, 4'd0, 4'd1);
    rcv_cmd = 1; rcv_src_x = 4'd3; rcv_src_y = 4'd2;
    put_req(4'd0, 4'd1);
    out_ack = 0; cyc();
    for (int i = 0; i < TIMEOUT + 6; i++) begin out_ack = (i % 4 != 2); cyc(); end
    put_head(4'd3, 4'd2, 1); put_pay(32'h33330001); idle(2);

    tag = "R2";
    for (int i = 0; i < DEPTH; i++) put_word(32'hC0000000 + 32'(i), 0, 4'd2, 4'd0);
    tag = "R9"; put_word(32'hC00000FF, 1, 4'd2, 4'd0);
    tag = "R5"; put_req(4'd2, 4'd0); idle(DEPTH + 3);

    tag = "R7/R8";
    ask(4'd1, 4'd0);
    cyc();
    idle(TIMEOUT - 1);
    put_head(4'd1, 4'd0, 1); put_pay(32'h44440001);
    idle(TIMEOUT + 3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule